// File: doc/BRIEF.md
# Vectored Local-Bus Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt request lines from local-bus devices and presents one combined interrupt to the processor. Each line is sampled into a source register on every clock. The source register is combined with a software-owned enable mask. The combined output is high whenever any enabled source is active.

An interrupt handler does not scan bit fields. It reads a vector register that already holds a scaled number for the winning source: the source index plus one, shifted left by two. It reads zero when nothing is pending, so the value can index a jump table of 4-byte entries directly. The vector register and the enable mask share a small 16-bit register space. That space accepts byte, halfword and 32-bit accesses. A 32-bit access is split into two halfword accesses, and a byte write merges into the current halfword.

Top module: `vic_top`

## Requirements
- R1: The source register takes the level of each `irqIn` line on every rising clock edge. A source bit is set while its line is high and cleared while it is low; nothing is held after a line drops.
- R2: `irqOut` is high exactly when the bitwise AND of the source register and the enable mask is nonzero.
- R3: The vector register at byte offset 0x0 reads (n + 1) << 2, where n is the index of the selected pending source. It reads 0 when no source is pending.
- R4: When several sources are pending, the lowest index is the one encoded in the vector.
- R5: While `rstN` is low, the source register is cleared, the enable mask holds 0x0010 (only index 4 enabled) and `irqOut` is low.
- R6: The enable mask sits at byte offset 0x2. A halfword access there reads it, and a halfword write replaces all 16 bits.
- R7: `busSize` = 0 is a byte access. `busAddr[0]` = 0 selects bits 7:0 of the halfword and 1 selects bits 15:8. A byte read returns that byte in `busRdata[7:0]` with the upper bits zero. A byte write takes `busWdata[7:0]` into that byte and keeps the other byte of the halfword.
- R8: `busSize` = 2 is a 32-bit access. It ignores `busAddr[0]`, maps the halfword at the address to bits 15:0 and the halfword at address + 2 (modulo the address space) to bits 31:16, for reads and writes alike. `busSize` = 1 or 3 is a halfword access with `busAddr[0]` ignored.
- R9: The vector register is read-only. Writes of any size that land on offset 0x0 change no state.
- R10: Halfword offsets other than 0x0 and 0x2 read as zero and ignore writes.
- R11: A mask write takes effect on `irqOut` and on the vector from the cycle after the write edge. A change on `irqIn` is seen from the cycle after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SRC (16) | Level-sensitive device interrupt requests |
| busAddr | input | ADDR_W (12) | Byte address within the register space |
| busSize | input | 2 | Access size: 0 byte, 1 or 3 halfword, 2 word |
| busWr | input | 1 | Write strobe for the current access |
| busWdata | input | 32 | Write data; bytes use bits 7:0, halfwords bits 15:0 |
| busRdata | output | 32 | Read data for the current address and size (combinational) |
| irqOut | output | 1 | Combined interrupt request to the processor |

## Verification
On every cycle, the assertions check four things. The source register tracks the inputs one edge late. The output agrees with a nonzero vector. The encoded source is enabled, active and has no active, enabled source below it. The mask changes only when the decoder issues a mask strobe, and that strobe is never raised by writes aimed at the vector offset.

Some behaviours can only be shown by the bench's scenarios, which compare against a behavioural model on every clock: the exact vector values, byte merging into the correct half, the word split with address wrap-around, zero reads from unmapped offsets, and the reset value of the mask.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_HALF_ALT = 2'b11
  } accSize_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_VEC  = 2'b01,
    SEL_MASK = 2'b10
  } regSel_e;

  typedef struct packed {
    logic [1:0]       maskBe;
    logic [REG_W-1:0] maskData;
    regSel_e          rdLo;
    regSel_e          rdHi;
    logic             rdByte;
    logic             rdByteHi;
  } vicStrobe_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] VEC_OFF  = 'h0,
  parameter logic [ADDR_W-1:0] MASK_OFF = 'h2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  output vicStrobe_t        strobe
);

  logic [ADDR_W-1:0] halfAddr;
  logic [ADDR_W-1:0] upperAddr;
  regSel_e           loSel;
  regSel_e           hiSel;
  accSize_e          accSize;

  function automatic regSel_e selOf(input logic [ADDR_W-1:0] a);
    if (a == VEC_OFF)       return SEL_VEC;
    else if (a == MASK_OFF) return SEL_MASK;
    else                    return SEL_NONE;
  endfunction

  assign accSize   = accSize_e'(busSize);
  assign halfAddr  = {busAddr[ADDR_W-1:1], 1'b0};
  assign upperAddr = halfAddr + ADDR_W'(2);
  assign loSel     = selOf(halfAddr);
  assign hiSel     = selOf(upperAddr);

  always_comb begin
    strobe = '0;
    strobe.rdLo = loSel;
    case (accSize)
      SZ_BYTE: begin
        strobe.rdByte   = 1'b1;
        strobe.rdByteHi = busAddr[0];
        if (busWr && loSel == SEL_MASK) begin
          strobe.maskBe   = busAddr[0] ? 2'b10 : 2'b01;
          strobe.maskData = {busWdata[7:0], busWdata[7:0]};
        end
      end
      SZ_WORD: begin
        strobe.rdHi = hiSel;
        if (busWr && loSel == SEL_MASK) begin
          strobe.maskBe   = 2'b11;
          strobe.maskData = busWdata[15:0];
        end else if (busWr && hiSel == SEL_MASK) begin
          strobe.maskBe   = 2'b11;
          strobe.maskData = busWdata[31:16];
        end
      end
      default: begin
        if (busWr && loSel == SEL_MASK) begin
          strobe.maskBe   = 2'b11;
          strobe.maskData = busWdata[15:0];
        end
      end
    endcase
  end

  // R9
  vec_write_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && accSize != SZ_WORD && halfAddr == VEC_OFF) |-> (strobe.maskBe == 2'b00));

  // R7
  byte_single_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == SZ_BYTE) |-> ($countones(strobe.maskBe) <= 1));

  // R10
  unmapped_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfAddr != VEC_OFF && halfAddr != MASK_OFF && accSize != SZ_WORD)
      |-> (strobe.maskBe == 2'b00));

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter logic [REG_W-1:0] MASK_RST = 16'h0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  vicStrobe_t         strobe,
  output logic [31:0]        rdData,
  output logic               irqOut
);

  localparam int IDX_W   = $clog2(NUM_SRC + 1);
  localparam int N_BYTES = REG_W / 8;

  logic [NUM_SRC-1:0] srcReg;
  logic [7:0]         maskByte [N_BYTES];
  logic [REG_W-1:0]   maskReg;
  logic [NUM_SRC-1:0] pending;
  logic [IDX_W-1:0]   winIdx;
  logic               winHit;
  logic [REG_W-1:0]   vecVal;
  logic [REG_W-1:0]   loHalf;
  logic [REG_W-1:0]   hiHalf;

  always_ff @(posedge clk) begin
    if (!rstN) srcReg <= '0;
    else       srcReg <= irqIn;
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_maskLane
    always_ff @(posedge clk) begin
      if (!rstN)                maskByte[b] <= MASK_RST[8*b +: 8];
      else if (strobe.maskBe[b]) maskByte[b] <= strobe.maskData[8*b +: 8];
    end
    assign maskReg[8*b +: 8] = maskByte[b];
  end

  assign pending = srcReg & maskReg[NUM_SRC-1:0];
  assign irqOut  = |pending;

  always_comb begin
    winIdx = '0;
    winHit = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        winIdx = IDX_W'(i);
        winHit = 1'b1;
      end
    end
  end

  assign vecVal = winHit ? (REG_W'(winIdx) + REG_W'(1)) << 2 : '0;

  function automatic logic [REG_W-1:0] halfOf(input regSel_e sel,
                                              input logic [REG_W-1:0] vec,
                                              input logic [REG_W-1:0] msk);
    case (sel)
      SEL_VEC:  return vec;
      SEL_MASK: return msk;
      default:  return '0;
    endcase
  endfunction

  assign loHalf = halfOf(strobe.rdLo, vecVal, maskReg);
  assign hiHalf = halfOf(strobe.rdHi, vecVal, maskReg);

  always_comb begin
    if (strobe.rdByte)
      rdData = {24'b0, strobe.rdByteHi ? loHalf[15:8] : loHalf[7:0]};
    else
      rdData = {hiHalf, loHalf};
  end

  // checker logic
  logic [REG_W-1:0]   vecIdx;
  logic [NUM_SRC-1:0] belowWin;
  assign vecIdx = (vecVal >> 2) - REG_W'(1);
  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) belowWin[i] = (REG_W'(i) < vecIdx);
  end

  // R1
  src_tracks_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (srcReg == $past(irqIn)));

  // R2
  out_matches_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (vecVal != '0));

  // R3
  vector_is_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecVal != '0) |-> (srcReg[vecIdx[IDX_W-1:0]] && maskReg[vecIdx[IDX_W-1:0]]
                        && vecVal[1:0] == 2'b00));

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vecVal != '0) |-> ((srcReg & maskReg[NUM_SRC-1:0] & belowWin) == '0));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskBe == 2'b00) |=> $stable(maskReg));

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [1:0]         busSize,
  input  logic               busWr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irqOut
);

  vicStrobe_t strobe;

  vic_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busSize(busSize),
    .busWr(busWr),
    .busWdata(busWdata),
    .strobe(strobe)
  );

  vic_datapath #(
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .irqIn(irqIn),
    .strobe(strobe),
    .rdData(busRdata),
    .irqOut(irqOut)
  );

endmodule

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [11:0] busAddr = '0;
  logic [1:0]  busSize = 2'd1;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  int mSrc  = 0;
  int mMask = 'h10;

  always #5 clk = ~clk;

  vic_top uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busSize(busSize), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic int modelVec();
    int p = mSrc & mMask;
    for (int i = 0; i < 16; i++) if ((p >> i) & 1) return (i + 1) * 4;
    return 0;
  endfunction

  function automatic int rdHalf(int off);
    off = off & 'hFFF;
    if (off == 0) return modelVec();
    if (off == 2) return mMask;
    return 0;
  endfunction

  function automatic void wrHalf(int off, int val);
    if ((off & 'hFFF) == 2) mMask = val & 'hFFFF;
  endfunction

  function automatic int modelRead(int a, int sz);
    int h = a & 'hFFE;
    if (sz == 0) return (rdHalf(h) >> (8 * (a & 1))) & 'hFF;
    if (sz == 2) return rdHalf(h) | (rdHalf(h + 2) << 16);
    return rdHalf(h);
  endfunction

  function automatic void modelWrite(int a, int sz, int d);
    int h = a & 'hFFE;
    int old = rdHalf(h);
    if (sz == 0) begin
      if (a & 1) wrHalf(h, (old & 'h00FF) | ((d & 'hFF) << 8));
      else       wrHalf(h, (old & 'hFF00) | (d & 'hFF));
    end else if (sz == 2) begin
      wrHalf(h, d & 'hFFFF);
      wrHalf(h + 2, (d >> 16) & 'hFFFF);
    end else begin
      wrHalf(h, d & 'hFFFF);
    end
  endfunction

  task automatic step(input logic [15:0] irq, input int a, input int sz,
                      input bit wr, input int d, input string tag);
    int expRd;
    bit expIrq;
    @(negedge clk);
    irqIn = irq; busAddr = 12'(a); busSize = 2'(sz); busWr = wr; busWdata = d;
    #1;
    expRd  = modelRead(a, sz);
    expIrq = ((mSrc & mMask) != 0);
    nChecks++;
    if (irqOut !== expIrq) begin
      nFails++;
      $display("FAIL %s irqOut actual %0b expected %0b", tag, irqOut, expIrq);
    end
    nChecks++;
    if (busRdata !== 32'(expRd)) begin
      nFails++;
      $display("FAIL %s busRdata actual %08h expected %08h (addr %03h size %0d)",
               tag, busRdata, expRd, a, sz);
    end
    @(posedge clk);
    if (!rstN) begin
      mSrc = 0; mMask = 'h10;
    end else begin
      if (wr) modelWrite(a, sz, d);
      mSrc = irq;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R5: reset state, inputs active but held cleared
    step(16'hFFFF, 2, 1, 0, 0, "R5");
    step(16'hFFFF, 0, 1, 1, 'hFFFF, "R5");
    step(16'h0000, 2, 2, 0, 0, "R5");
    @(negedge clk); rstN = 1'b1;
    // R1/R2/R3: only index 4 enabled after reset
    step(16'h0010, 0, 1, 0, 0, "R1");
    step(16'h0001, 0, 1, 0, 0, "R3");
    step(16'h0000, 0, 1, 0, 0, "R2");
    step(16'h0000, 2, 1, 0, 0, "R5");
    // R6: full mask write, R11 visible next cycle
    step(16'h0A00, 2, 1, 1, 'hFFFF, "R6");
    step(16'h0A00, 0, 1, 0, 0, "R11");
    step(16'h8421, 0, 1, 0, 0, "R4");
    step(16'h8000, 0, 1, 0, 0, "R3");
    step(16'h8000, 2, 1, 1, 'h7FFF, "R11");
    step(16'h8000, 0, 1, 0, 0, "R2");
    // R7: byte merge and byte reads
    step(16'h0000, 3, 0, 1, 'h5A, "R7");
    step(16'h0000, 2, 0, 1, 'hC3, "R7");
    step(16'h0000, 3, 0, 0, 0, "R7");
    step(16'h0000, 2, 0, 0, 0, "R7");
    step(16'h0080, 0, 0, 0, 0, "R7");
    step(16'h0080, 1, 0, 0, 0, "R7");
    // R8: word split, address bit 0 ignored, wrap
    step(16'h0000, 1, 2, 1, 'h1234_ABCD, "R8");
    step(16'h0004, 0, 2, 0, 0, "R8");
    step(16'h0004, 3, 2, 1, 'h9999_00F0, "R8");
    step(16'h00F0, 2, 2, 0, 0, "R8");
    step(16'h00F0, 'hFFE, 2, 0, 0, "R8");
    step(16'h00F0, 3, 3, 0, 0, "R8");
    // R9: writes at the vector offset change nothing
    step(16'h0010, 0, 1, 1, 'h0000, "R9");
    step(16'h0010, 1, 0, 1, 'h00, "R9");
    step(16'h0010, 2, 1, 0, 0, "R9");
    step(16'h0010, 0, 1, 0, 0, "R9");
    // R10: unmapped offsets
    step(16'h0010, 4, 1, 1, 'hFFFF, "R10");
    step(16'h0010, 'h10, 2, 1, 'hFFFF_FFFF, "R10");
    step(16'h0010, 5, 0, 0, 0, "R10");
    step(16'h0010, 2, 1, 0, 0, "R10");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom_range(0, 5);
      int a = (sel < 4) ? sel : ((sel == 4) ? 'hFFE : $urandom_range(0, 'hFFF));
      step(16'($urandom), a, $urandom_range(0, 3), bit'($urandom_range(0, 1)),
           int'($urandom), "R2");
    end
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule